// File: doc/BRIEF.md
# BCD Real-Time Clock Counter Chain

This block is the timekeeping core of a small real-time clock. A 100 Hz enable pulse, produced elsewhere, steps a chain of eight byte-wide BCD counters. The chain covers hundredths of a second, seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. Each counter carries into the next when it wraps. The day-of-month counter knows each month's length, and February gets a 29th day in years divisible by four. The hours byte runs in either 12-hour or 24-hour form.

A host-side access controller reads the whole time through a 64-bit snapshot output. It writes all eight bytes at once through a parallel load strobe. Two control flags sit in the spare bits of the day-of-week byte. One stops the counting. The other tells the access controller whether to obey its external reset pin, and the block exports it on a separate output.

Top module: `bcd_rtc_chain`

## Requirements
- R1: After reset the snapshot reads, from byte 7 down to byte 0, 00 01 01 31 00 00 00 00 (hex). This is 24-hour mode at 00:00:00.00 on day-of-week 1, month 01, date 01, year 00, with both control flags set.
- R2: Byte k of the snapshot and of the load word occupies bits [8k+7:8k]. The byte order is hundredths (0), seconds (1), minutes (2), hours (3), day-of-week (4), date (5), month (6) and year (7). Each tick while running adds one hundredth. Hundredths wrap 99 to 00 and carry into seconds. Seconds and minutes wrap 59 to 00 and carry onward.
- R3: When hours bit 7 is 0 (24-hour mode), hours count 00 to 23 in bits 5:0. Past 23 they return to 00 and carry one day.
- R4: When hours bit 7 is 1 (12-hour mode), bits 4:0 hold 01 to 12 and bit 5 is PM. Hour 11 steps to 12 and flips bit 5. Hour 12 steps to 01 and keeps bit 5. Only the step from 11 PM to 12 AM carries one day.
- R5: The day-of-week counter in bits 2:0 of byte 4 counts 1 to 7 and returns to 1 on each day carry, whatever the date does. Bits 5:4 of that byte are not changed by counting.
- R6: The date returns to 01 and carries into the month after day 30 in months 04, 06, 09 and 11. In the other months except February it does so after day 31.
- R7: February ends after day 29 when the year is a multiple of 4 (00 counts as one), and after day 28 otherwise.
- R8: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R9: While byte 4 bit 5 is 1, ticks have no effect and all eight bytes hold.
- R10: Output rst_ignore_o always equals byte 4 bit 4, the flag that tells the access controller to ignore its reset pin.
- R11: Undefined bits read 0 whatever was loaded. The bits kept are seconds 0x7F, minutes 0x7F, hours 0xBF, day-of-week 0x37, date 0x3F and month 0x1F. Hundredths and year keep all bits.
- R12: A load replaces all eight bytes in the next cycle, even when a tick arrives in the same cycle. Counting then resumes from the loaded hundredths value.
- R13: In a cycle with neither tick nor load, no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 100 Hz count enable, one clock wide |
| load_i | input | 1 | Parallel load strobe |
| load_data_i | input | 64 | Eight BCD bytes to load, byte 0 in bits 7:0 |
| time_o | output | 64 | Snapshot of the eight registers |
| rst_ignore_o | output | 1 | Reset-ignore flag for the access controller |

## Verification
A host load and a 100 Hz tick can arrive in the same clock. A load can also carry the stop flag that freezes the ticks which follow it. The bench drives load and tick together at several points, including just before a hundredths rollover. The expected result is the loaded word with nothing added, followed by normal counting from the loaded value. An independent field-level model is compared with the snapshot after every clock.

// File: rtl/bcd_rtc_chain.sv
module bcd_rtc_chain #(
  parameter int NBYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  load_i,
  input  logic [NBYTES*8-1:0]   load_data_i,
  output logic [NBYTES*8-1:0]   time_o,
  output logic                  rst_ignore_o
);
  localparam int W = NBYTES * 8;
  localparam logic [63:0] KEEP = 64'hFF_1F_3F_37_BF_7F_7F_FF;
  localparam logic [63:0] INIT = 64'h00_01_01_31_00_00_00_00;

  logic [7:0] hs, sc, mn, hr, dw, dt, mo, yr;

  function automatic logic [7:0] inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic run, leap, c0, c1, c2, c3, c4, c5, hr_wrap;
  logic [7:0] last_day, hr_nxt, hs_i, sc_i, mn_i, dt_i, mo_i, yr_i, h12_i, h24_i;

  assign run = tick_i && !dw[5];
  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  always_comb begin
    case (mo)
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      default:                    last_day = 8'h31;
    endcase
  end

  assign hs_i  = inc(hs);
  assign sc_i  = inc(sc);
  assign mn_i  = inc(mn);
  assign dt_i  = inc(dt);
  assign mo_i  = inc(mo);
  assign yr_i  = inc(yr);
  assign h12_i = inc({3'b000, hr[4:0]});
  assign h24_i = inc({2'b00, hr[5:0]});

  assign hr_wrap = hr[7] ? (hr[5] && hr[4:0] == 5'h11) : (hr[5:0] == 6'h23);

  always_comb begin
    if (hr[7]) begin
      if (hr[4:0] == 5'h11)      hr_nxt = {2'b10, ~hr[5], 5'h12};
      else if (hr[4:0] == 5'h12) hr_nxt = {hr[7:5], 5'h01};
      else                       hr_nxt = {hr[7:5], h12_i[4:0]};
    end else begin
      hr_nxt = hr_wrap ? 8'h00 : {2'b00, h24_i[5:0]};
    end
  end

  assign c0 = run && hs == 8'h99;
  assign c1 = c0 && sc == 8'h59;
  assign c2 = c1 && mn == 8'h59;
  assign c3 = c2 && hr_wrap;
  assign c4 = c3 && dt >= last_day;
  assign c5 = c4 && mo >= 8'h12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {yr, mo, dt, dw, hr, mn, sc, hs} <= INIT;
    end else if (load_i) begin
      {yr, mo, dt, dw, hr, mn, sc, hs} <= load_data_i & KEEP;
    end else if (run) begin
      hs <= c0 ? 8'h00 : hs_i;
      if (c0) sc <= c1 ? 8'h00 : sc_i;
      if (c1) mn <= c2 ? 8'h00 : mn_i;
      if (c2) hr <= hr_nxt;
      if (c3) begin
        dw <= {dw[7:3], (dw[2:0] == 3'd7) ? 3'd1 : dw[2:0] + 3'd1};
        dt <= c4 ? 8'h01 : dt_i;
      end
      if (c4) mo <= c5 ? 8'h01 : mo_i;
      if (c5) yr <= (yr == 8'h99) ? 8'h00 : yr_i;
    end
  end

  assign time_o = W'({yr, mo, dt, dw, hr, mn, sc, hs});
  assign rst_ignore_o = dw[4];
endmodule

// File: rtl/bcd_rtc_chain_chk.sv
module bcd_rtc_chain_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        load_i,
  input logic [63:0] load_data_i,
  input logic [63:0] time_o,
  input logic        rst_ignore_o
);
  localparam logic [63:0] KEEP = 64'hFF_1F_3F_37_BF_7F_7F_FF;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> time_o == ($past(load_data_i) & KEEP)); // R12

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (time_o & ~KEEP) == 64'd0); // R11

  AST_OSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && time_o[37]) |=> $stable(time_o)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(time_o)); // R13

  AST_HUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && !time_o[37] && time_o[3:0] != 4'd9)
      |=> time_o[3:0] == $past(time_o[3:0]) + 4'd1); // R2

  AST_FLAG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(time_o[36]) |-> rst_ignore_o); // R10
endmodule

bind bcd_rtc_chain bcd_rtc_chain_chk u_chk (.*);

// File: tb/bcd_rtc_chain_bench.sv
`timescale 1ns/100ps
module bcd_rtc_chain_bench;
  logic clk = 0, rst_n = 0, tick_i = 0, load_i = 0;
  logic [63:0] load_data_i = '0, time_o;
  logic rst_ignore_o;
  int checks = 0, errors = 0;
  bit done = 0;

  bcd_rtc_chain u_bcd_rtc_chain (.*);
  always #2.5 clk = ~clk;

  int m_hund, m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year;
  bit m_h12, m_pm, m_osc, m_rsten;

  function automatic logic [7:0] b(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int d(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [63:0] mk(bit h12, bit pm, int h, int mi, int s, int cs,
                                     int dw, bit osc, bit rsten, int dt, int mo, int yr);
    logic [7:0] hb;
    hb = h12 ? (8'h80 | (pm ? 8'h20 : 8'h00) | b(h)) : b(h);
    return {b(yr), b(mo), b(dt), 2'b00, osc, rsten, 1'b0, 3'(dw), hb, b(mi), b(s), b(cs)};
  endfunction

  function automatic logic [63:0] model_word();
    return mk(m_h12, m_pm, m_hour, m_min, m_sec, m_hund, m_dow, m_osc, m_rsten,
              m_date, m_mon, m_year);
  endfunction

  task automatic model_load(logic [63:0] v);
    m_hund = d(v[7:0]); m_sec = d({1'b0, v[14:8]}); m_min = d({1'b0, v[22:16]});
    m_h12 = v[31];
    m_pm = v[31] & v[29];
    m_hour = v[31] ? d({3'b0, v[28:24]}) : d({2'b0, v[29:24]});
    m_dow = int'(v[34:32]); m_rsten = v[36]; m_osc = v[37];
    m_date = d({2'b0, v[45:40]}); m_mon = d({3'b0, v[52:48]}); m_year = d(v[63:56]);
  endtask

  task automatic model_tick();
    int dim;
    bit day;
    day = 0;
    m_hund++;
    if (m_hund < 100) return;
    m_hund = 0; m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0;
    if (m_h12) begin
      if (m_hour == 11) begin m_hour = 12; day = m_pm; m_pm = !m_pm; end
      else if (m_hour == 12) m_hour = 1;
      else m_hour++;
    end else begin
      m_hour++;
      if (m_hour == 24) begin m_hour = 0; day = 1; end
    end
    if (!day) return;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) dim = 30;
    else if (m_mon == 2) dim = (m_year % 4 == 0) ? 29 : 28;
    else dim = 31;
    if (m_date < dim) begin m_date++; return; end
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_year = (m_year + 1) % 100;
  endtask

  task automatic check(string tag);
    logic [63:0] e;
    e = model_word();
    checks++;
    if (time_o !== e) begin
      errors++;
      $display("FAIL %s time_o actual=%h expected=%h", tag, time_o, e);
    end
    checks++;
    if (rst_ignore_o !== m_rsten) begin
      errors++;
      $display("FAIL R10 rst_ignore_o actual=%b expected=%b", rst_ignore_o, m_rsten);
    end
  endtask

  task automatic step(bit tk, bit ld, logic [63:0] v, string tag);
    tick_i = tk; load_i = ld; load_data_i = v;
    @(posedge clk);
    if (ld) model_load(v);
    else if (tk && !m_osc) model_tick();
    @(negedge clk);
    check(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 64'h0, tag);
    tick_i = 0;
  endtask

  task automatic load(logic [63:0] v, string tag);
    step(0, 1, v, tag);
    load_i = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_load(64'h00_01_01_31_00_00_00_00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");
    ticks(5, "R9");
    for (int i = 0; i < 4; i++) step(0, 0, 64'h0, "R13");

    load(mk(0, 0, 9, 59, 59, 50, 3, 0, 1, 14, 5, 21), "R12");
    ticks(60, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 64'h0, "R13");

    load(mk(0, 0, 23, 59, 59, 90, 7, 0, 0, 31, 12, 99), "R12");
    ticks(20, "R3 R5 R8");

    load(mk(1, 0, 11, 59, 59, 95, 2, 0, 1, 10, 3, 30), "R4");
    ticks(10, "R4");
    load(mk(1, 1, 12, 59, 59, 98, 2, 0, 1, 10, 3, 30), "R4");
    ticks(5, "R4");
    load(mk(1, 1, 11, 59, 59, 98, 4, 0, 0, 30, 4, 30), "R4");
    ticks(5, "R4 R6");

    load(mk(0, 0, 23, 59, 59, 99, 1, 0, 0, 30, 6, 10), "R6");
    ticks(2, "R6");
    load(mk(0, 0, 23, 59, 59, 99, 1, 0, 0, 31, 1, 10), "R6");
    ticks(2, "R6");
    load(mk(0, 0, 23, 59, 59, 99, 1, 0, 0, 30, 1, 10), "R6");
    ticks(2, "R6");

    load(mk(0, 0, 23, 59, 59, 99, 5, 0, 0, 28, 2, 23), "R7");
    ticks(2, "R7");
    load(mk(0, 0, 23, 59, 59, 99, 5, 0, 0, 28, 2, 24), "R7");
    ticks(2, "R7");
    load(mk(0, 0, 23, 59, 59, 99, 6, 0, 0, 29, 2, 0), "R7");
    ticks(2, "R7");

    load(mk(0, 0, 15, 30, 45, 12, 3, 0, 0, 12, 7, 50) |
         64'h00_E0_C0_C8_40_80_80_00, "R11");
    ticks(3, "R11");

    load(mk(0, 0, 8, 0, 0, 97, 1, 0, 0, 1, 1, 1), "R12");
    step(1, 1, mk(0, 0, 8, 0, 0, 98, 1, 0, 1, 1, 1, 1), "R12");
    ticks(4, "R12");
    step(1, 1, mk(0, 0, 8, 0, 0, 40, 1, 1, 1, 1, 1, 1), "R12 R9");
    ticks(6, "R9");
    load(mk(0, 0, 8, 0, 0, 40, 1, 0, 0, 1, 1, 1), "R10");
    for (int i = 0; i < 30; i++) step(i % 3 == 0, 0, 64'h0, "R2 R13");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule